// File: doc/BRIEF.md
# Display Refresh RAM Controller

The block keeps a sixteen-location, byte-wide store of display characters and plays it out to a multiplexed digit display. An external scan counter names the digit being lit. For that digit the block presents the upper half of the stored byte on port A and the lower half on port B. A single blank cycle separates one digit from the next, so that no segment of the old digit shows at the new position.

The CPU loads characters through a strobe and a data byte. A two-bit mode chooses the entry order, which is either a moving pointer or a shift in from the right. The same mode chooses the span, either 8 or 16 digits. Two inhibit bits protect either half of every location a write touches. Two blank bits suppress either output half. A clear input empties the store and returns the pointer to the first digit.

Top module: `disp_refresh_ctrl`

## Requirements
- R1: When scan_i holds the same value on two consecutive clock edges, the outputs after the second edge show the addressed location: port_a_o = bits 7:4, port_b_o = bits 3:0, blank_o = 0.
- R2: Left entry is selected by mode_i[1] = 0. Each write stores wr_data_i at the write pointer and then advances the pointer. The pointer wraps to 0 after location 7 for mode 00 and after location 15 for mode 01. The pointer is 0 after reset and after clear.
- R3: Right entry is selected by mode_i[1] = 1, with span 8 for mode 10 and span 16 for mode 11. Each write stores wr_data_i at location span-1, moves locations 1..span-1 down by one and discards location 0. Locations at or above the span keep their contents.
- R4: When inh_hi_i is 1, bits 7:4 of every location a write touches keep their value. When inh_lo_i is 1, bits 3:0 keep their value. This holds for shifted locations too. The left-entry pointer still advances.
- R5: When scan_i differs from its value at the previous edge, the outputs after that edge are port_a_o = 0, port_b_o = 0 and blank_o = 1.
- R6: blank_hi_i = 1 forces port_a_o to 0, and blank_lo_i = 1 forces port_b_o to 0. Both take effect with the same one-edge latency as the data.
- R7: clear_i fills all 16 locations with 8'h00 and sets the pointer to 0. It takes priority over a write strobe in the same cycle.
- R8: In the 8-digit modes (mode_i[0] = 0), the displayed location is scan_i[2:0]. For example, scan 9 shows location 1.
- R9: During reset, port_a_o and port_b_o are 0, blank_o is 1 and every location holds 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scan_i | input | 4 | Current digit from the scan counter |
| mode_i | input | 2 | Bit 1: right entry; bit 0: 16-digit span |
| wr_i | input | 1 | CPU write strobe, one write per cycle high |
| wr_data_i | input | 8 | Character to write |
| clear_i | input | 1 | Fill store with 8'h00, reset pointer |
| inh_hi_i | input | 1 | Protect bits 7:4 from writes |
| inh_lo_i | input | 1 | Protect bits 3:0 from writes |
| blank_hi_i | input | 1 | Force port A to 0 |
| blank_lo_i | input | 1 | Force port B to 0 |
| port_a_o | output | 4 | Upper half of current digit |
| port_b_o | output | 4 | Lower half of current digit |
| blank_o | output | 1 | High in the inter-digit blank cycle |

## Verification
Distinct byte values are written, so that a wrong address or a missed shift shows as a wrong character. Short left-entry runs separate pointer advance from storage. Runs of 9 and 17 characters expose wrap and overflow in both spans. A right-entry run after a 16-digit fill separates the shift span from the untouched upper half. Writes under each inhibit bit, in both entry orders, show whether the protected half moves during a shift. Repeated and changed scan values tell the blank cycle apart from steady refresh, and scan values above 7 in 8-digit modes confirm address folding.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [1:0] {
    MODE_L8  = 2'b00,
    MODE_L16 = 2'b01,
    MODE_R8  = 2'b10,
    MODE_R16 = 2'b11
  } disp_mode_e;

  function automatic logic mode_right(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_wide(input logic [1:0] m);
    return m[0];
  endfunction
endpackage

// File: rtl/disp_wr_ctrl.sv
module disp_wr_ctrl
  import disp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          wr_i,
  input  logic          clear_i,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] last_idx_o,
  output logic          left_we_o,
  output logic          right_we_o
);
  localparam logic [AW-1:0] LAST_WIDE   = AW'(DEPTH - 1);
  localparam logic [AW-1:0] LAST_NARROW = AW'(DEPTH / 2 - 1);

  logic [AW-1:0] ptr_q;

  assign last_idx_o = mode_wide(mode_i) ? LAST_WIDE : LAST_NARROW;
  assign left_we_o  = wr_i && !clear_i && !mode_right(mode_i);
  assign right_we_o = wr_i && !clear_i && mode_right(mode_i);
  assign wr_ptr_o   = ptr_q;

  // pointer beyond span (after a mode change) also wraps home
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (clear_i) begin
      ptr_q <= '0;
    end else if (left_we_o) begin
      if (ptr_q >= last_idx_o) ptr_q <= '0;
      else                     ptr_q <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/disp_ram.sv
module disp_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int NW = DW / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                left_we_i,
  input  logic                right_we_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [AW-1:0]       last_idx_i,
  input  logic [DW-1:0]       wr_data_i,
  input  logic                inh_hi_i,
  input  logic                inh_lo_i,
  output logic [DEPTH*DW-1:0] ram_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic          hit;
      logic [DW-1:0] cand;
      hit = (left_we_i && wr_addr_i == AW'(i)) ||
            (right_we_i && AW'(i) <= last_idx_i);
      if (right_we_i && AW'(i) != last_idx_i) cand = mem_q[(i + 1) % DEPTH];
      else                                    cand = wr_data_i;
      mem_d[i] = mem_q[i];
      if (hit && !inh_hi_i) mem_d[i][DW-1:NW] = cand[DW-1:NW];
      if (hit && !inh_lo_i) mem_d[i][NW-1:0]  = cand[NW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clear_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign ram_o[g*DW +: DW] = mem_q[g];
  end
endmodule

// File: rtl/disp_scan_out.sv
module disp_scan_out #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int NW = DW / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       scan_i,
  input  logic                wide_i,
  input  logic [DEPTH*DW-1:0] ram_i,
  input  logic                blank_hi_i,
  input  logic                blank_lo_i,
  output logic [NW-1:0]       port_a_o,
  output logic [NW-1:0]       port_b_o,
  output logic                blank_o
);
  logic [AW-1:0] scan_q;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  // narrow span folds the scan onto the lower half
  assign rd_addr = wide_i ? scan_i : {1'b0, scan_i[AW-2:0]};
  assign rd_data = ram_i[int'(rd_addr)*DW +: DW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_q   <= '0;
      port_a_o <= '0;
      port_b_o <= '0;
      blank_o  <= 1'b1;
    end else begin
      scan_q <= scan_i;
      if (scan_i != scan_q) begin
        port_a_o <= '0;
        port_b_o <= '0;
        blank_o  <= 1'b1;
      end else begin
        port_a_o <= blank_hi_i ? '0 : rd_data[DW-1:NW];
        port_b_o <= blank_lo_i ? '0 : rd_data[NW-1:0];
        blank_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/disp_refresh_ctrl.sv
module disp_refresh_ctrl
  import disp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int NW = DW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] scan_i,
  input  logic [1:0]    mode_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          clear_i,
  input  logic          inh_hi_i,
  input  logic          inh_lo_i,
  input  logic          blank_hi_i,
  input  logic          blank_lo_i,
  output logic [NW-1:0] port_a_o,
  output logic [NW-1:0] port_b_o,
  output logic          blank_o
);
  logic [AW-1:0]       wr_ptr;
  logic [AW-1:0]       last_idx;
  logic                left_we;
  logic                right_we;
  logic [DEPTH*DW-1:0] ram_q;

  disp_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .wr_i       (wr_i),
    .clear_i    (clear_i),
    .wr_ptr_o   (wr_ptr),
    .last_idx_o (last_idx),
    .left_we_o  (left_we),
    .right_we_o (right_we)
  );

  disp_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .left_we_i  (left_we),
    .right_we_i (right_we),
    .wr_addr_i  (wr_ptr),
    .last_idx_i (last_idx),
    .wr_data_i  (wr_data_i),
    .inh_hi_i   (inh_hi_i),
    .inh_lo_i   (inh_lo_i),
    .ram_o      (ram_q)
  );

  disp_scan_out #(.DEPTH(DEPTH), .DW(DW)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scan_i     (scan_i),
    .wide_i     (mode_wide(mode_i)),
    .ram_i      (ram_q),
    .blank_hi_i (blank_hi_i),
    .blank_lo_i (blank_lo_i),
    .port_a_o   (port_a_o),
    .port_b_o   (port_b_o),
    .blank_o    (blank_o)
  );
endmodule

// File: rtl/disp_refresh_chk.sv
module disp_refresh_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int NW = DW / 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [AW-1:0]       scan_i,
  input logic [1:0]          mode_i,
  input logic                wr_i,
  input logic                clear_i,
  input logic                inh_hi_i,
  input logic                inh_lo_i,
  input logic                blank_hi_i,
  input logic                blank_lo_i,
  input logic [NW-1:0]       port_a_o,
  input logic [NW-1:0]       port_b_o,
  input logic                blank_o,
  input logic [AW-1:0]       wr_ptr,
  input logic [DEPTH*DW-1:0] ram_q
);
  logic [AW-1:0] prev_scan;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_scan <= '0;
    else         prev_scan <= scan_i;
  end

  assert_blank_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> (port_a_o == '0 && port_b_o == '0));

  assert_blank_on_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_i != prev_scan) |=> blank_o);

  assert_steady_no_blank_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_i == prev_scan) |=> !blank_o);

  assert_hi_blanked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_hi_i |=> (port_a_o == '0));

  assert_lo_blanked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_lo_i |=> (port_b_o == '0));

  assert_clear_ptr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (wr_ptr == '0 && ram_q == '0));

  assert_narrow_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clear_i && mode_i == 2'b00) |=> (wr_ptr < AW'(DEPTH / 2)));

  assert_full_inhibit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clear_i && inh_hi_i && inh_lo_i) |=> $stable(ram_q));
endmodule

bind disp_refresh_ctrl disp_refresh_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scan_i     (scan_i),
  .mode_i     (mode_i),
  .wr_i       (wr_i),
  .clear_i    (clear_i),
  .inh_hi_i   (inh_hi_i),
  .inh_lo_i   (inh_lo_i),
  .blank_hi_i (blank_hi_i),
  .blank_lo_i (blank_lo_i),
  .port_a_o   (port_a_o),
  .port_b_o   (port_b_o),
  .blank_o    (blank_o),
  .wr_ptr     (wr_ptr),
  .ram_q      (ram_q)
);

// File: tb/sim_disp_refresh_ctrl.sv
`timescale 1ns/1ps
module sim_disp_refresh_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] scan_i = '0;
  logic [1:0] mode_i = '0;
  logic       wr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       clear_i = 1'b0;
  logic       inh_hi_i = 1'b0, inh_lo_i = 1'b0;
  logic       blank_hi_i = 1'b0, blank_lo_i = 1'b0;
  logic [3:0] port_a_o, port_b_o;
  logic       blank_o;

  disp_refresh_ctrl u0 (.*);

  always #2 clk_i = ~clk_i;

  typedef struct {
    int         due;
    logic [3:0] a;
    logic [3:0] b;
    logic       bl;
    string      tag;
  } item_t;

  item_t      exp_q[$];
  int         cyc = 0;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;
  logic [7:0] mdl[16];
  int         ptr = 0;
  int         last_scan = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor
  always @(negedge clk_i) begin
    if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      item_t it;
      it = exp_q.pop_front();
      n_run++;
      if (port_a_o !== it.a || port_b_o !== it.b || blank_o !== it.bl) begin
        n_fail++;
        $display("FAIL %s: a=%h b=%h bl=%b exp a=%h b=%h bl=%b",
                 it.tag, port_a_o, port_b_o, blank_o, it.a, it.b, it.bl);
      end
    end
  end

  task automatic do_clear(input bit with_wr);
    clear_i = 1'b1; wr_i = with_wr; wr_data_i = 8'hEE;
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    ptr = 0;
    @(negedge clk_i);
    clear_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    int last;
    logic [7:0] old[16];
    last = mode_i[0] ? 15 : 7;
    for (int i = 0; i < 16; i++) old[i] = mdl[i];
    if (!mode_i[1]) begin
      if (!inh_hi_i) mdl[ptr][7:4] = d[7:4];
      if (!inh_lo_i) mdl[ptr][3:0] = d[3:0];
      ptr = (ptr >= last) ? 0 : ptr + 1;
    end else begin
      for (int i = 0; i <= last; i++) begin
        logic [7:0] nv;
        nv = (i == last) ? d : old[i+1];
        if (!inh_hi_i) mdl[i][7:4] = nv[7:4];
        if (!inh_lo_i) mdl[i][3:0] = nv[3:0];
      end
    end
    wr_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic show(input int d, input string tag);
    item_t it;
    int addr, dly;
    addr = mode_i[0] ? d : d % 8;
    dly = 1;
    if (d != last_scan) begin
      it = '{due: cyc + 1, a: 4'h0, b: 4'h0, bl: 1'b1, tag: "R5"};
      exp_q.push_back(it);
      dly = 2;
    end
    it.due = cyc + dly;
    it.a = blank_hi_i ? 4'h0 : mdl[addr][7:4];
    it.b = blank_lo_i ? 4'h0 : mdl[addr][3:0];
    it.bl = 1'b0;
    it.tag = tag;
    exp_q.push_back(it);
    scan_i = 4'(d);
    last_scan = d;
    repeat (dly) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not end, exp done=1 got 0");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    n_run++;
    if (port_a_o !== 4'h0 || port_b_o !== 4'h0 || blank_o !== 1'b1) begin
      n_fail++;
      $display("FAIL R9: a=%h b=%h bl=%b exp a=0 b=0 bl=1", port_a_o, port_b_o, blank_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    show(0, "R9");

    // left entry, 16 digits
    mode_i = 2'b01;
    for (int i = 0; i < 5; i++) do_write(8'h11 * (i + 1));
    for (int i = 0; i < 6; i++) show(i, "R2");
    show(5, "R1");
    for (int i = 5; i < 16; i++) do_write(8'h40 + 8'(i));
    do_write(8'hC3);
    show(0, "R2");
    show(15, "R2");
    show(1, "R1");

    // left entry, 8 digits, wrap and folded scan
    mode_i = 2'b00;
    do_clear(0);
    for (int i = 0; i < 9; i++) do_write(8'h21 + 8'(i));
    show(0, "R2");
    show(7, "R2");
    show(9, "R8");
    show(14, "R8");

    // right entry, 8 digits after a 16-digit fill
    mode_i = 2'b01;
    do_clear(0);
    for (int i = 0; i < 9; i++) do_write(8'h31 + 8'(i));
    mode_i = 2'b10;
    do_write(8'h5A);
    show(7, "R3");
    show(0, "R3");
    show(6, "R3");
    mode_i = 2'b01;
    show(8, "R3");

    // right entry, 16 digits, overflow
    mode_i = 2'b11;
    do_clear(0);
    for (int i = 0; i < 17; i++) do_write(8'h60 + 8'(i));
    show(0, "R3");
    show(15, "R3");
    show(14, "R3");

    // inhibit, left entry
    mode_i = 2'b01;
    do_clear(0);
    do_write(8'hAB);
    inh_hi_i = 1'b1; do_write(8'hCD); inh_hi_i = 1'b0;
    inh_lo_i = 1'b1; do_write(8'hEF); inh_lo_i = 1'b0;
    inh_hi_i = 1'b1; inh_lo_i = 1'b1; do_write(8'h99);
    inh_hi_i = 1'b0; inh_lo_i = 1'b0;
    do_write(8'h77);
    for (int i = 0; i < 5; i++) show(i, "R4");

    // inhibit, right entry shift
    mode_i = 2'b11;
    do_clear(0);
    do_write(8'h12);
    inh_hi_i = 1'b1; do_write(8'h34); inh_hi_i = 1'b0;
    show(15, "R4");
    show(14, "R4");

    // per-half blanking
    blank_hi_i = 1'b1;
    show(15, "R6");
    show(15, "R6");
    blank_hi_i = 1'b0; blank_lo_i = 1'b1;
    show(14, "R6");
    blank_lo_i = 1'b0;
    show(14, "R6");

    // clear priority over write
    mode_i = 2'b01;
    do_clear(1);
    show(15, "R7");
    show(0, "R7");
    do_write(8'h5C);
    show(1, "R7");
    show(0, "R7");

    repeat (4) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL R1: %0d results not seen, exp 0", exp_q.size());
    end
    finish_run();
  end
endmodule